// File: doc/BRIEF.md
# Refresh and Power-Down Command Arbiter

This block sits between a memory controller's user command queue and its command issue stage. Each cycle it decides whether the issue stage sends a refresh, enters or leaves power-down, enters or leaves self-refresh, or lets the head read/write request through. A user refresh request outranks any waiting read or write. Self-refresh is entered and left only when the user asks.

The block watches the queue. When the queue has stayed empty for a programmable number of consecutive cycles, it puts the memory into power-down on its own. Any new request, or a refresh, brings the memory back out. A fixed exit delay follows before the first command is granted. A small register port rewrites the idle timeout at run time. The same port reads back the stored timeout and a powered-down status bit.

Top module: `pwr_refresh_arbiter`

## Requirements
- R1: After reset the block is active (not powered down, not in self-refresh). No command strobe and no grant is asserted. `cfg_rdata` reads `{1'b0, RST_TIMEOUT}`.
- R2: In the active state a refresh request (`ref_req` this cycle or one still pending) raises `cmd_refresh` in that same cycle. `rw_grant` stays low in that cycle even when `rw_valid` is high. The read/write is granted in a later cycle.
- R3: A cycle counts as idle only when `q_empty` is high, no refresh or self-refresh entry is pending, and the block is active. Any non-idle cycle restarts the idle count from zero.
- R4: On the N-th consecutive idle cycle, where N is the latched timeout, `cmd_pd_enter` is raised and the block enters power-down. With N = 1 this happens on the first idle cycle.
- R5: A write on the register port stores `cfg_wdata` as the timeout. A written value of 0 is stored as 1. `cfg_rdata[TMO_W-1:0]` returns the stored timeout.
- R6: The timeout is latched at the start of each idle period. A write during an idle period changes only the following periods.
- R7: `cfg_rdata[TMO_W]` is 1 exactly while the block is in power-down. This includes the cycle that raises `cmd_pd_exit`.
- R8: In power-down, a non-empty queue, a valid read/write or a refresh or self-refresh request raises `cmd_pd_exit` in that cycle. Then follow EXIT_DLY (default 3) cycles with no strobe and no grant. Normal arbitration resumes in the next cycle.
- R9: `sr_enter` in the active state raises `cmd_sr_enter`, ahead of read/write and idle power-down. In self-refresh there is no grant and no power-down. `sr_exit` raises `cmd_sr_exit` and then the same EXIT_DLY quiet cycles. `sr_exit` outside self-refresh is ignored.
- R10: At most one of the five command strobes is high in any cycle. In the bench's encoding the order is `{refresh, pd_enter, pd_exit, sr_enter, sr_exit}`.
- R11: A refresh request seen during power-down, exit delay or self-refresh is held. It is issued as `cmd_refresh` in the first active cycle, ahead of a waiting read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_empty | input | 1 | Command queue holds no read/write request |
| rw_valid | input | 1 | Head read/write request is valid |
| ref_req | input | 1 | User refresh request (pulse or level) |
| sr_enter | input | 1 | User request to enter self-refresh |
| sr_exit | input | 1 | User request to leave self-refresh |
| cfg_we | input | 1 | Register port write strobe for the idle timeout |
| cfg_wdata | input | TMO_W | Timeout value to write |
| cfg_rdata | output | TMO_W+1 | {powered-down status, stored timeout} |
| rw_grant | output | 1 | Head read/write may issue this cycle |
| cmd_refresh | output | 1 | Issue refresh command |
| cmd_pd_enter | output | 1 | Issue power-down entry |
| cmd_pd_exit | output | 1 | Issue power-down exit |
| cmd_sr_enter | output | 1 | Issue self-refresh entry |
| cmd_sr_exit | output | 1 | Issue self-refresh exit |

## Verification
If the state register holds the wrong value, the fault shows up in the same cycle on the strobes or the grant. A grant appears during self-refresh or inside the exit delay, or a power-down entry or exit appears out of turn. If the idle counter or the latched timeout drifts, `cmd_pd_enter` moves by one or more cycles against the count of idle cycles. A lost refresh pending flag shows as a missing `cmd_refresh` in the first active cycle after a wake. A broken timeout store shows up at once in the `cfg_rdata` readback.

// File: rtl/pra_pkg.sv
package pra_pkg;
   typedef enum logic [1:0] {
      ST_ACT  = 2'd0,
      ST_PD   = 2'd1,
      ST_WAKE = 2'd2,
      ST_SR   = 2'd3
   } pra_state_e;

   localparam int STB_N   = 5;
   localparam int STB_REF = 4;
   localparam int STB_PDE = 3;
   localparam int STB_PDX = 2;
   localparam int STB_SRE = 1;
   localparam int STB_SRX = 0;

   localparam int RQ_N   = 2;
   localparam int RQ_REF = 0;
   localparam int RQ_SR  = 1;
endpackage

// File: rtl/pra_req_hold.sv
module pra_req_hold #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] take_i,
   input  logic [N-1:0] drop_i,
   output logic [N-1:0] want_o
);
   initial begin
      assert (N >= 1) else $error("pra_req_hold: N must be at least 1");
   end

   logic [N-1:0] pend_q;

   assign want_o = req_i | pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= want_o & ~take_i & ~drop_i;
   end

   for (genvar i = 0; i < N; i++) begin : g_chk
      assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (want_o[i] && !take_i[i] && !drop_i[i]) |=> want_o[i]);
   end
endmodule

// File: rtl/pra_idle_timer.sv
module pra_idle_timer #(
   parameter int TMO_W       = 16,
   parameter int RST_TIMEOUT = 16,
   parameter bit ZERO_CLAMP  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [TMO_W-1:0] cfg_wdata,
   input  logic             idle_i,
   output logic             hit_o,
   output logic [TMO_W-1:0] tmo_o
);
   localparam logic [TMO_W-1:0] TMO_RST = TMO_W'(RST_TIMEOUT);
   localparam logic [TMO_W-1:0] TMO_ONE = TMO_W'(1);

   initial begin
      assert (TMO_W >= 1 && TMO_W <= 32) else $error("pra_idle_timer: TMO_W out of range");
      assert (RST_TIMEOUT >= 1 && RST_TIMEOUT < (64'd1 << TMO_W))
         else $error("pra_idle_timer: RST_TIMEOUT out of range");
   end

   logic [TMO_W-1:0] cfg_q, lat_q, cnt_q, wr_val;
   logic [TMO_W:0]   cnt_inc;

   if (ZERO_CLAMP) begin : g_clamp
      assign wr_val = (cfg_wdata == '0) ? TMO_ONE : cfg_wdata;
   end else begin : g_reject
      assign wr_val = (cfg_wdata == '0) ? cfg_q : cfg_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q <= TMO_RST;
      else if (cfg_we) cfg_q <= wr_val;
   end

   assign cnt_inc = {1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1};
   assign hit_o   = idle_i && (cnt_inc >= {1'b0, lat_q});
   assign tmo_o   = cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lat_q <= TMO_RST;
      end else if (!idle_i) begin
         cnt_q <= '0;
         lat_q <= cfg_q;
      end else if (hit_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_inc[TMO_W-1:0];
      end
   end

   assert_tmo_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q != '0);
   assert_hit_needs_idle_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && lat_q > TMO_ONE) |-> $past(idle_i));
   if (ZERO_CLAMP) begin : g_clamp_chk
      assert_zero_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_wdata == '0) |=> cfg_q == TMO_ONE);
   end
   assert_restart_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_i && $past(!idle_i)) |-> !hit_o);
endmodule

// File: rtl/pra_ctrl_fsm.sv
module pra_ctrl_fsm
   import pra_pkg::*;
#(
   parameter int EXIT_DLY = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             q_empty_i,
   input  logic             rw_valid_i,
   input  logic             ref_want_i,
   input  logic             sr_want_i,
   input  logic             sr_exit_i,
   input  logic             tmr_hit_i,
   output logic             idle_o,
   output logic             ref_take_o,
   output logic             sr_take_o,
   output logic             rw_grant_o,
   output logic [STB_N-1:0] stb_o,
   output logic             in_pd_o
);
   localparam int DW = (EXIT_DLY < 2) ? 1 : $clog2(EXIT_DLY);
   localparam logic [DW-1:0] DLY_LAST = DW'(EXIT_DLY - 1);

   initial begin
      assert (EXIT_DLY >= 1) else $error("pra_ctrl_fsm: EXIT_DLY must be at least 1");
   end

   pra_state_e st_q, st_d;
   logic [DW-1:0] dly_q, dly_d;
   logic wake_req;

   assign wake_req = !q_empty_i || rw_valid_i || ref_want_i || sr_want_i;
   assign idle_o   = (st_q == ST_ACT) && q_empty_i && !ref_want_i && !sr_want_i;
   assign in_pd_o  = (st_q == ST_PD);

   always_comb begin
      st_d       = st_q;
      dly_d      = dly_q;
      stb_o      = '0;
      rw_grant_o = 1'b0;
      ref_take_o = 1'b0;
      sr_take_o  = 1'b0;
      unique case (st_q)
         ST_ACT: begin
            if (ref_want_i) begin
               stb_o[STB_REF] = 1'b1;
               ref_take_o     = 1'b1;
            end else if (sr_want_i) begin
               stb_o[STB_SRE] = 1'b1;
               sr_take_o      = 1'b1;
               st_d           = ST_SR;
            end else if (rw_valid_i) begin
               rw_grant_o = 1'b1;
            end else if (tmr_hit_i) begin
               stb_o[STB_PDE] = 1'b1;
               st_d           = ST_PD;
            end
         end
         ST_PD: begin
            if (wake_req) begin
               stb_o[STB_PDX] = 1'b1;
               st_d           = ST_WAKE;
               dly_d          = '0;
            end
         end
         ST_WAKE: begin
            if (dly_q == DLY_LAST) begin
               st_d  = ST_ACT;
               dly_d = '0;
            end else begin
               dly_d = dly_q + DW'(1);
            end
         end
         ST_SR: begin
            sr_take_o = sr_want_i;
            if (sr_exit_i) begin
               stb_o[STB_SRX] = 1'b1;
               st_d           = ST_WAKE;
               dly_d          = '0;
            end
         end
         default: st_d = ST_ACT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_ACT;
         dly_q <= '0;
      end else begin
         st_q  <= st_d;
         dly_q <= dly_d;
      end
   end

   assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb_o));
   assert_no_grant_after_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o[STB_PDX] |=> !rw_grant_o);
   assert_sr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o[STB_SRE] |=> (!rw_grant_o && !stb_o[STB_PDE]));
   assert_refresh_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rw_grant_o |-> !ref_want_i);
   assert_pd_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o[STB_PDE] |=> in_pd_o);
endmodule

// File: rtl/pwr_refresh_arbiter.sv
module pwr_refresh_arbiter
   import pra_pkg::*;
#(
   parameter int TMO_W       = 16,
   parameter int RST_TIMEOUT = 16,
   parameter int EXIT_DLY    = 3,
   parameter bit ZERO_CLAMP  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             q_empty,
   input  logic             rw_valid,
   input  logic             ref_req,
   input  logic             sr_enter,
   input  logic             sr_exit,
   input  logic             cfg_we,
   input  logic [TMO_W-1:0] cfg_wdata,
   output logic [TMO_W:0]   cfg_rdata,
   output logic             rw_grant,
   output logic             cmd_refresh,
   output logic             cmd_pd_enter,
   output logic             cmd_pd_exit,
   output logic             cmd_sr_enter,
   output logic             cmd_sr_exit
);
   logic [RQ_N-1:0]  rq_in, rq_take, rq_drop, rq_want;
   logic [STB_N-1:0] stb;
   logic [TMO_W-1:0] tmo;
   logic idle, hit, in_pd, ref_take, sr_take;

   assign rq_in[RQ_REF]   = ref_req;
   assign rq_in[RQ_SR]    = sr_enter;
   assign rq_take[RQ_REF] = ref_take;
   assign rq_take[RQ_SR]  = sr_take;
   assign rq_drop[RQ_REF] = 1'b0;
   assign rq_drop[RQ_SR]  = sr_exit;

   pra_req_hold #(.N(RQ_N)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (rq_in),
      .take_i (rq_take),
      .drop_i (rq_drop),
      .want_o (rq_want)
   );

   pra_idle_timer #(
      .TMO_W       (TMO_W),
      .RST_TIMEOUT (RST_TIMEOUT),
      .ZERO_CLAMP  (ZERO_CLAMP)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .idle_i    (idle),
      .hit_o     (hit),
      .tmo_o     (tmo)
   );

   pra_ctrl_fsm #(.EXIT_DLY(EXIT_DLY)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .q_empty_i  (q_empty),
      .rw_valid_i (rw_valid),
      .ref_want_i (rq_want[RQ_REF]),
      .sr_want_i  (rq_want[RQ_SR]),
      .sr_exit_i  (sr_exit),
      .tmr_hit_i  (hit),
      .idle_o     (idle),
      .ref_take_o (ref_take),
      .sr_take_o  (sr_take),
      .rw_grant_o (rw_grant),
      .stb_o      (stb),
      .in_pd_o    (in_pd)
   );

   assign cfg_rdata    = {in_pd, tmo};
   assign cmd_refresh  = stb[STB_REF];
   assign cmd_pd_enter = stb[STB_PDE];
   assign cmd_pd_exit  = stb[STB_PDX];
   assign cmd_sr_enter = stb[STB_SRE];
   assign cmd_sr_exit  = stb[STB_SRX];

   assert_pd_enter_on_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pd_enter |-> q_empty);
endmodule

// File: tb/pwr_refresh_arbiter_tb.sv
`timescale 1ns/1ps
module pwr_refresh_arbiter_tb;
   localparam int TW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic q_empty = 1'b0, rw_valid = 1'b0, ref_req = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
   logic cfg_we = 1'b0;
   logic [TW-1:0] cfg_wdata = '0;
   logic [TW:0] cfg_rdata;
   logic rw_grant, cmd_refresh, cmd_pd_enter, cmd_pd_exit, cmd_sr_enter, cmd_sr_exit;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwr_refresh_arbiter #(.TMO_W(TW), .RST_TIMEOUT(16), .EXIT_DLY(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .rw_valid(rw_valid),
      .ref_req(ref_req), .sr_enter(sr_enter), .sr_exit(sr_exit),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .rw_grant(rw_grant), .cmd_refresh(cmd_refresh), .cmd_pd_enter(cmd_pd_enter),
      .cmd_pd_exit(cmd_pd_exit), .cmd_sr_enter(cmd_sr_enter), .cmd_sr_exit(cmd_sr_exit));

   // {q_empty, rw_valid, ref_req, sr_enter, sr_exit, strobes{ref,pde,pdx,sre,srx}, grant, pd}
   localparam logic [11:0] VEC [32] = '{
      12'b01000_00000_1_0, 12'b01100_10000_0_0, 12'b01000_00000_1_0, 12'b10000_00000_0_0,
      12'b10000_01000_0_0, 12'b10000_00000_0_1, 12'b01000_00100_0_1, 12'b01000_00000_0_0,
      12'b01000_00000_0_0, 12'b01000_00000_0_0, 12'b01000_00000_1_0, 12'b10000_00000_0_0,
      12'b00000_00000_0_0, 12'b10000_00000_0_0, 12'b10000_01000_0_0, 12'b10100_00100_0_1,
      12'b10000_00000_0_0, 12'b10000_00000_0_0, 12'b10000_00000_0_0, 12'b10000_10000_0_0,
      12'b10000_00000_0_0, 12'b10010_00010_0_0, 12'b01000_00000_0_0, 12'b10000_00000_0_0,
      12'b10100_00000_0_0, 12'b10000_00000_0_0, 12'b01001_00001_0_0, 12'b01000_00000_0_0,
      12'b01000_00000_0_0, 12'b01000_00000_0_0, 12'b01000_10000_0_0, 12'b01000_00000_1_0
   };

   function automatic string vec_tag(input int i);
      if (i == 1 || i == 2)  return "R2";
      if (i == 4)            return "R4";
      if (i == 5)            return "R7";
      if (i >= 6 && i <= 10) return "R8";
      if (i >= 11 && i <= 14) return "R3";
      if (i >= 15 && i <= 19) return "R11";
      if (i >= 21 && i <= 29) return "R9";
      if (i >= 30)           return "R11";
      return "R10";
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic qe, input logic rw, input logic rf, input logic se,
                      input logic sx, input logic we = 1'b0, input logic [TW-1:0] wd = '0);
      @(posedge clk);
      #0.5;
      q_empty = qe; rw_valid = rw; ref_req = rf; sr_enter = se; sr_exit = sx;
      cfg_we = we; cfg_wdata = wd;
      @(negedge clk);
   endtask

   function automatic logic [6:0] outs();
      return {cmd_refresh, cmd_pd_enter, cmd_pd_exit, cmd_sr_enter, cmd_sr_exit,
              rw_grant, cfg_rdata[TW]};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", 32'(outs()), 32'd0);
      check("R1", 32'(cfg_rdata), {15'd0, 1'b0, 16'd16});

      // program timeout 2 while busy, then one busy cycle to latch it
      cyc(0, 0, 0, 0, 0, 1'b1, 16'd2);
      cyc(0, 0, 0, 0, 0);
      check("R5", 32'(cfg_rdata), 32'd2);

      for (int i = 0; i < 32; i++) begin
         cyc(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7]);
         check(vec_tag(i), 32'(outs()), 32'(VEC[i][6:0]));
      end

      // R6: write mid-count only affects the next idle period
      cyc(0, 0, 0, 0, 0, 1'b1, 16'd4);
      cyc(0, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0);
      check("R6", 32'(cmd_pd_enter), 32'd0);
      cyc(1, 0, 0, 0, 0, 1'b1, 16'd2);
      check("R6", 32'(cmd_pd_enter), 32'd0);
      cyc(1, 0, 0, 0, 0);
      check("R6", 32'(cmd_pd_enter), 32'd0);
      check("R5", 32'(cfg_rdata), 32'd2);
      cyc(1, 0, 0, 0, 0);
      check("R6", 32'(cmd_pd_enter), 32'd1);
      cyc(0, 1, 0, 0, 0);
      check("R8", 32'(outs()), 32'b0010001);
      for (int k = 0; k < 3; k++) begin
         cyc(0, 1, 0, 0, 0);
         check("R8", 32'(outs()), 32'd0);
      end
      cyc(0, 1, 0, 0, 0);
      check("R8", 32'(rw_grant), 32'd1);
      cyc(1, 0, 0, 0, 0);
      check("R6", 32'(cmd_pd_enter), 32'd0);
      cyc(1, 0, 0, 0, 0);
      check("R6", 32'(cmd_pd_enter), 32'd1);

      // R5: zero clamps to one; R7 status read while powered down
      cyc(1, 0, 0, 0, 0, 1'b1, 16'd0);
      cyc(1, 0, 0, 0, 0);
      check("R5", 32'(cfg_rdata), {15'd0, 1'b1, 16'd1});
      cyc(0, 1, 0, 0, 0);
      for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0, 0);
      cyc(1, 0, 0, 0, 0);
      check("R4", 32'(cmd_pd_enter), 32'd1);
      cyc(0, 1, 0, 0, 0);
      for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0, 0);

      // R9: sr_exit in active state is ignored
      cyc(0, 1, 0, 0, 1);
      check("R9", 32'(outs()), 32'b0000010);
      cyc(0, 0, 0, 0, 0);
      check("R9", 32'(outs()), 32'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule